// File: doc/BRIEF.md
# Modem status change detector

This block watches four modem handshake lines: clear-to-send, data-set-ready, ring indicator and carrier detect. Each line passes through a two-flop synchroniser. The block then compares each line with its previous synchronised level. Each comparison that finds an event sets a sticky flag. The block presents an 8-bit status byte. The low nibble holds the four flags and the high nibble holds the present synchronised levels. All lines are active high at the ports: a 1 means the line is asserted.

Three of the lines flag any change, rising or falling. The ring indicator flags only its trailing edge, that is, when it goes from active to inactive. When the host reads the status byte, it pulses the read strobe, and that pulse clears the flags. A modem-status interrupt request is the OR of the four flags, gated by an enable input. In loop mode, the block's own modem-control outputs are routed onto the four status inputs in place of the external pins. This lets software test the path without a cable.

Top module: `modem_status_watch`

## Requirements
- R1: While reset is asserted and on its release with all lines low, status is 8'h00 and the interrupt request is 0.
- R2: Status bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier detect) set on any change of their line, in either direction. The flag is visible after the third rising clock edge that follows the input change.
- R3: Status bit 2 sets only when the synchronised ring indicator goes from 1 to 0. A 0-to-1 change of ring indicator leaves bit 2 at 0.
- R4: A read strobe that is high at a rising edge clears all four flags at that edge.
- R5: Status bits 4, 5, 6 and 7 show the synchronised level of clear-to-send, data-set-ready, ring indicator and carrier detect in that order. Each level is visible after the second rising edge that follows its input change.
- R6: An event detected in the same cycle as a read strobe leaves its flag set after that edge.
- R7: The interrupt request is 1 exactly when the enable input is 1 and at least one of status bits 0 to 3 is 1.
- R8: With loop mode at 1, the line sources are as follows: request-to-send drives clear-to-send, terminal-ready drives data-set-ready, control output 1 drives ring indicator and control output 2 drives carrier detect. The external pins then have no effect on status.
- R9: Without a read strobe, a set flag stays set whatever the lines do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_cts | input | 1 | External clear-to-send, asynchronous |
| pin_dsr | input | 1 | External data-set-ready, asynchronous |
| pin_ri | input | 1 | External ring indicator, asynchronous |
| pin_dcd | input | 1 | External carrier detect, asynchronous |
| loop_en | input | 1 | Selects the modem-control outputs as line sources |
| ctl_rts | input | 1 | Request-to-send control output, looped to clear-to-send |
| ctl_dtr | input | 1 | Terminal-ready control output, looped to data-set-ready |
| ctl_out1 | input | 1 | Control output 1, looped to ring indicator |
| ctl_out2 | input | 1 | Control output 2, looped to carrier detect |
| rd_stb | input | 1 | Host read of the status byte; clears the flags |
| irq_en | input | 1 | Modem-status interrupt enable |
| status | output | 8 | Flags in bits 3:0, line levels in bits 7:4 |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The first patterns are single steps of each line in both directions. They separate the change-on-any-edge lines from the ring indicator, which must ignore its leading edge. Reads are placed both after an event and exactly in the cycle its detection lands, to separate a plain clear from the set-wins case. Loop mode runs with the external pins held opposite to the control outputs, which exposes any wrong pairing or leak from the pins. A long pseudo-random run of toggles, reads, enable and loop changes is compared every cycle against a behavioural history model.

// File: rtl/modem_status_watch.sv
module modem_status_watch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_cts,
  input  logic       pin_dsr,
  input  logic       pin_ri,
  input  logic       pin_dcd,
  input  logic       loop_en,
  input  logic       ctl_rts,
  input  logic       ctl_dtr,
  input  logic       ctl_out1,
  input  logic       ctl_out2,
  input  logic       rd_stb,
  input  logic       irq_en,
  output logic [7:0] status,
  output logic       irq
);

  logic [3:0] src, sync1, sync2, prv, delta, flags;

  assign src = loop_en ? {ctl_out2, ctl_out1, ctl_dtr, ctl_rts}
                       : {pin_dcd, pin_ri, pin_dsr, pin_cts};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prv   <= '0;
    end else begin
      sync1 <= src;
      sync2 <= sync1;
      prv   <= sync2;
    end
  end

  assign delta = {sync2[3] ^ prv[3],
                  prv[2] & ~sync2[2],
                  sync2[1] ^ prv[1],
                  sync2[0] ^ prv[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (rd_stb ? 4'b0000 : flags) | delta;
  end

  assign status = {sync2, flags};
  assign irq    = irq_en & (|flags);

  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && delta == 4'b0000) |=> (status[3:0] == 4'b0000));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (delta != 4'b0000) |=> ((status[3:0] & $past(delta)) == $past(delta)));

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((status[3:0] & $past(status[3:0])) == $past(status[3:0])));

  // R3
  ri_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> ($past(status[6], 2) && !$past(status[6])));

  // R2
  cts_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> ($past(status[4], 2) != $past(status[4])));

  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status[3:0] != 4'b0000));

endmodule

// File: tb/modem_status_watch_bench.sv
module modem_status_watch_bench;
  logic clk = 0, rst_n = 0;
  logic pin_cts = 0, pin_dsr = 0, pin_ri = 0, pin_dcd = 0;
  logic loop_en = 0, ctl_rts = 0, ctl_dtr = 0, ctl_out1 = 0, ctl_out2 = 0;
  logic rd_stb = 0, irq_en = 0;
  logic [7:0] status;
  logic irq;

  int checks = 0, fails = 0;
  bit h1 [4], h2 [4], h3 [4];
  bit mflag [4];

  modem_status_watch u_modem_status_watch (.*);

  always #5 clk = ~clk;

  function automatic bit line_src(int i);
    if (loop_en) begin
      case (i) 0: return ctl_rts; 1: return ctl_dtr; 2: return ctl_out1; default: return ctl_out2; endcase
    end
    case (i) 0: return pin_cts; 1: return pin_dsr; 2: return pin_ri; default: return pin_dcd; endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin h1[i] = 0; h2[i] = 0; h3[i] = 0; mflag[i] = 0; end
    end else begin
      for (int i = 0; i < 4; i++) begin
        bit ev;
        ev = (i == 2) ? (h3[i] && !h2[i]) : (h3[i] != h2[i]);
        mflag[i] = (rd_stb ? 1'b0 : mflag[i]) | ev;
        h3[i] = h2[i];
        h2[i] = h1[i];
        h1[i] = line_src(i);
      end
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      logic [3:0] ef, el;
      logic any;
      any = 0;
      for (int i = 0; i < 4; i++) begin ef[i] = mflag[i]; el[i] = h2[i]; any |= mflag[i]; end
      check("R2/R3/R4/R6/R9 flags", {4'h0, status[3:0]}, {4'h0, ef});
      check("R5/R8 levels", {4'h0, status[7:4]}, {4'h0, el});
      check("R7 irq", {7'h0, irq}, {7'h0, irq_en & any});
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_pulse;
    @(negedge clk) rd_stb = 1;
    @(negedge clk) rd_stb = 0;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cyc(1);
    check("R1 reset status", status, 8'h00);
    check("R1 reset irq", {7'h0, irq}, 8'h00);
    cyc(2); rst_n = 1;
    cyc(1);
    check("R1 after release", status, 8'h00);

    pin_cts = 1; cyc(2);
    check("R5 cts level after two edges", status, 8'h10);
    cyc(1);
    check("R2 cts rise flag", status, 8'h11);
    rd_pulse;
    check("R4 read clears", status, 8'h10);
    pin_cts = 0; cyc(4);
    check("R2 cts fall flag", status, 8'h01);
    cyc(5);
    check("R9 flag sticky", status, 8'h01);
    rd_pulse;

    pin_ri = 1; cyc(4);
    check("R3 ri leading edge ignored", status, 8'h40);
    pin_ri = 0; cyc(4);
    check("R3 ri trailing edge flags", status, 8'h04);
    check("R7 irq off when disabled", {7'h0, irq}, 8'h00);
    irq_en = 1; #1;
    check("R7 irq on when enabled", {7'h0, irq}, 8'h01);
    rd_pulse;
    check("R7 irq drops after read", {7'h0, irq}, 8'h00);

    pin_dcd = 1; pin_cts = 1; cyc(4); rd_pulse;
    pin_dsr = 1; cyc(2);
    rd_stb = 1; cyc(1); rd_stb = 0;
    check("R6 event during read stays", status, 8'hB2);
    rd_pulse;

    pin_cts = 0; pin_dsr = 0; pin_dcd = 0; cyc(4); rd_pulse;
    pin_cts = 1; pin_dsr = 1; pin_ri = 0; pin_dcd = 1;
    loop_en = 1; ctl_rts = 0; ctl_dtr = 0; ctl_out1 = 1; ctl_out2 = 0; cyc(4); rd_pulse;
    check("R8 out1 to ri, pins ignored", status, 8'h40);
    ctl_rts = 1; ctl_out1 = 0; cyc(4);
    check("R8 rts to cts", status, 8'h15);
    rd_pulse;
    ctl_dtr = 1; ctl_out2 = 1; cyc(4);
    check("R8 dtr to dsr, out2 to dcd", status, 8'hBA);
    pin_cts = 0; pin_dsr = 0; pin_dcd = 0; pin_ri = 1; rd_pulse; cyc(4);
    check("R8 pin changes no effect", status, 8'hB0);

    for (int k = 0; k < 3000; k++) begin
      int r;
      @(negedge clk);
      r = $urandom_range(0, 99);
      if (r < 8) pin_cts = ~pin_cts;
      else if (r < 16) pin_dsr = ~pin_dsr;
      else if (r < 24) pin_ri = ~pin_ri;
      else if (r < 32) pin_dcd = ~pin_dcd;
      else if (r < 36) ctl_rts = ~ctl_rts;
      else if (r < 40) ctl_out1 = ~ctl_out1;
      else if (r < 43) loop_en = ~loop_en;
      else if (r < 47) irq_en = ~irq_en;
      rd_stb = ($urandom_range(0, 9) == 0);
    end
    rd_stb = 0;
    cyc(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule